// File: doc/BRIEF.md
# Queued-Operation Serial Flash Engine

This block runs a serial flash bus under software control, one micro-operation at a time. Software loads a 14-bit operation word into a staging register, then commits it with a separate strobe into an operation queue. Each word names a short opcode and a byte count. The engine takes the words in order and carries out each one. It can lower or raise the chip select, clock a number of bytes out on the single data-out line, or clock a number of bytes in from the data-in line.

Payload bytes travel through one shared 8-bit data queue in both directions. Software pushes bytes for the engine to send, and pops the bytes the engine has received. The serial clock idles low, and data is sampled on its rising edge (SPI mode 0). Each half period of the serial clock lasts a parameterised number of system clocks. The engine pauses with the serial clock held low whenever the data queue cannot supply or accept a byte.

Top module: `spi_opq_engine`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, op_empty and dq_empty are 1, and op_full and dq_full are 0.
- R2: An operation word holds the byte count in bits 8:0 (0 to 511) and the opcode in bits 13:9. Loading the word with op_ld alone queues nothing; only an op_commit pulse while op_full is 0 enqueues the loaded word.
- R3: Opcode 1 drives cs_n low and opcode 0 drives it high. cs_n changes at no other time.
- R4: Opcode 0x08 with count N sends N bytes taken from the data queue, MSB first. mosi is stable at each rising edge of sclk.
- R5: Opcode 0x0C with count N receives N bytes, sampling miso on the rising edge, MSB first, and places them in the data queue in arrival order. mosi is held at 1 while these bytes are clocked.
- R6: A send operation that finds the data queue empty waits with sclk low and no clock edges until a byte is pushed.
- R7: A receive operation that finds the data queue full waits with sclk low and no clock edges after completing the byte in flight. No received byte is lost.
- R8: Operations execute strictly in commit order. op_full is 1 while OPQ_DEPTH words are pending. op_empty is 1 only when the queue is empty and the engine is idle.
- R9: dq_full and dq_empty reflect the data queue occupancy. A push while dq_full is 1 and a pop while dq_empty is 1 are ignored. dq_rdata shows the head byte.
- R10: Within a byte, consecutive rising edges of sclk are 2*HALF_DIV system clocks apart.
- R11: Any opcode other than 0, 1, 0x08 and 0x0C, and a send or receive with count 0, completes with no sclk edge and no change to cs_n.
- R12: A software push and a pop of the data queue in the same cycle both take effect. The head advances and the new byte is appended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_wdata | input | 14 | Operation word: opcode [13:9], byte count [8:0] |
| op_ld | input | 1 | Loads op_wdata into the staging register |
| op_commit | input | 1 | Enqueues the staged word |
| op_full | output | 1 | Operation queue holds OPQ_DEPTH words |
| op_empty | output | 1 | No pending word and engine idle |
| dq_wdata | input | 8 | Byte pushed by software |
| dq_push | input | 1 | Push strobe for dq_wdata |
| dq_pop | input | 1 | Advances the data queue past its head |
| dq_rdata | output | 8 | Head byte of the data queue |
| dq_full | output | 1 | Data queue full |
| dq_empty | output | 1 | Data queue empty |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The data queue has two users: software on one side and the engine on the other. In one cycle, a software pop can meet an engine store of a received byte. Likewise, a software push can meet an engine fetch of a byte to send. Long receive and send operations are therefore run while the bench pops or pushes with random gaps. This lets the two sides collide at many offsets. The result is judged by comparing every byte against a model of the serial stream. A directed case also applies push and pop in one cycle and checks the head and the remaining order.

// File: rtl/spi_opq_engine.sv
module spi_opq_engine #(
  parameter int OPQ_DEPTH = 8,
  parameter int DQ_DEPTH  = 16,
  parameter int HALF_DIV  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [13:0] op_wdata,
  input  logic        op_ld,
  input  logic        op_commit,
  output logic        op_full,
  output logic        op_empty,
  input  logic [7:0]  dq_wdata,
  input  logic        dq_push,
  input  logic        dq_pop,
  output logic [7:0]  dq_rdata,
  output logic        dq_full,
  output logic        dq_empty,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);
  localparam int OAW = (OPQ_DEPTH > 1) ? $clog2(OPQ_DEPTH) : 1;
  localparam int DAW = (DQ_DEPTH > 1) ? $clog2(DQ_DEPTH) : 1;
  localparam int HW  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [4:0] OPC_CS_HI = 5'h00;
  localparam logic [4:0] OPC_CS_LO = 5'h01;
  localparam logic [4:0] OPC_WR    = 5'h08;
  localparam logic [4:0] OPC_RD    = 5'h0C;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SHIFT, S_STORE} st_t;

  // operation queue
  logic [13:0]    op_word;
  logic [13:0]    oq_mem [OPQ_DEPTH];
  logic [OAW-1:0] oq_wp, oq_rp;
  logic [OAW:0]   oq_cnt;
  logic           oq_push, oq_pop;

  st_t        st;
  logic       cs_q, is_rd, ph;
  logic [8:0] rem;
  logic [7:0] tx, rx;
  logic [2:0] bitcnt;
  logic [HW-1:0] hcnt;

  wire [13:0] head   = oq_mem[oq_rp];
  wire [4:0]  hd_op  = head[13:9];
  wire [8:0]  hd_len = head[8:0];

  assign op_full  = (oq_cnt == (OAW+1)'(OPQ_DEPTH));
  assign op_empty = (oq_cnt == '0) && (st == S_IDLE);
  assign oq_push  = op_commit && !op_full;
  assign oq_pop   = (st == S_IDLE) && (oq_cnt != '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) op_word <= '0;
    else if (op_ld) op_word <= op_wdata;

  always_ff @(posedge clk)
    if (oq_push) oq_mem[oq_wp] <= op_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oq_wp  <= '0;
      oq_rp  <= '0;
      oq_cnt <= '0;
    end else begin
      if (oq_push) oq_wp <= (oq_wp == OAW'(OPQ_DEPTH-1)) ? '0 : oq_wp + 1'b1;
      if (oq_pop)  oq_rp <= (oq_rp == OAW'(OPQ_DEPTH-1)) ? '0 : oq_rp + 1'b1;
      if (oq_push && !oq_pop)      oq_cnt <= oq_cnt + 1'b1;
      else if (!oq_push && oq_pop) oq_cnt <= oq_cnt - 1'b1;
    end
  end

  // data queue
  logic [7:0]     dq_mem [DQ_DEPTH];
  logic [DAW-1:0] dq_wp, dq_rp;
  logic [DAW:0]   dq_cnt;

  wire eng_pop  = (st == S_LOAD) && !dq_empty;
  wire eng_push = (st == S_STORE) && !dq_full;
  wire sw_push  = dq_push && !dq_full && !eng_push;
  wire sw_pop   = dq_pop && !dq_empty && !eng_pop;
  wire q_push   = eng_push || sw_push;
  wire q_pop    = eng_pop || sw_pop;
  wire [7:0] q_wdata = eng_push ? rx : dq_wdata;

  assign dq_full  = (dq_cnt == (DAW+1)'(DQ_DEPTH));
  assign dq_empty = (dq_cnt == '0);
  assign dq_rdata = dq_mem[dq_rp];

  always_ff @(posedge clk)
    if (q_push) dq_mem[dq_wp] <= q_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_wp  <= '0;
      dq_rp  <= '0;
      dq_cnt <= '0;
    end else begin
      if (q_push) dq_wp <= (dq_wp == DAW'(DQ_DEPTH-1)) ? '0 : dq_wp + 1'b1;
      if (q_pop)  dq_rp <= (dq_rp == DAW'(DQ_DEPTH-1)) ? '0 : dq_rp + 1'b1;
      if (q_push && !q_pop)      dq_cnt <= dq_cnt + 1'b1;
      else if (!q_push && q_pop) dq_cnt <= dq_cnt - 1'b1;
    end
  end

  // serial engine
  wire ph_end = (hcnt == HW'(HALF_DIV-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cs_q <= 1'b1; is_rd <= 1'b0; ph <= 1'b0;
      rem <= '0; tx <= '0; rx <= '0; bitcnt <= '0; hcnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (oq_cnt != '0) begin
          if (hd_op == OPC_CS_HI) cs_q <= 1'b1;
          else if (hd_op == OPC_CS_LO) cs_q <= 1'b0;
          else if (hd_op == OPC_WR && hd_len != '0) begin
            rem <= hd_len; is_rd <= 1'b0; st <= S_LOAD;
          end else if (hd_op == OPC_RD && hd_len != '0) begin
            rem <= hd_len; is_rd <= 1'b1; tx <= 8'hFF;
            bitcnt <= '0; hcnt <= '0; ph <= 1'b0; st <= S_SHIFT;
          end
        end
        S_LOAD: if (!dq_empty) begin
          tx <= dq_rdata; bitcnt <= '0; hcnt <= '0; ph <= 1'b0; st <= S_SHIFT;
        end
        S_SHIFT: if (ph_end) begin
          hcnt <= '0;
          ph   <= ~ph;
          if (!ph) rx <= {rx[6:0], miso};
          else if (bitcnt != 3'd7) begin
            bitcnt <= bitcnt + 1'b1;
            tx     <= {tx[6:0], 1'b1};
          end else begin
            rem <= rem - 1'b1;
            if (is_rd) st <= S_STORE;
            else st <= (rem == 9'd1) ? S_IDLE : S_LOAD;
          end
        end else hcnt <= hcnt + 1'b1;
        S_STORE: if (!dq_full) begin
          if (rem == '0) st <= S_IDLE;
          else begin
            tx <= 8'hFF; bitcnt <= '0; hcnt <= '0; ph <= 1'b0; st <= S_SHIFT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign sclk = (st == S_SHIFT) && ph;
  assign cs_n = cs_q;
  assign mosi = (st == S_SHIFT) ? tx[7] : 1'b0;

  // R3
  cs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(cs_n));
  // R4
  mosi_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
  // R5
  rd_mosi_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && st == S_SHIFT) |-> mosi);
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_empty |-> !sclk);
  // R9
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_cnt <= (DAW+1)'(DQ_DEPTH)) && (oq_cnt <= (OAW+1)'(OPQ_DEPTH)));
  // R12
  dq_pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_push && q_pop) |=> $stable(dq_cnt));
endmodule

// File: tb/spi_opq_engine_tb_top.sv
module spi_opq_engine_tb_top;
  localparam int CLK_P = 10;
  localparam int HDIV  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [13:0] op_wdata = '0;
  logic op_ld = 1'b0, op_commit = 1'b0;
  logic op_full, op_empty;
  logic [7:0] dq_wdata = '0;
  logic dq_push = 1'b0, dq_pop = 1'b0;
  logic [7:0] dq_rdata;
  logic dq_full, dq_empty, sclk, cs_n, mosi, miso;

  always #(CLK_P/2) clk = ~clk;

  spi_opq_engine #(.OPQ_DEPTH(8), .DQ_DEPTH(16), .HALF_DIV(HDIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_wdata(op_wdata), .op_ld(op_ld),
    .op_commit(op_commit), .op_full(op_full), .op_empty(op_empty),
    .dq_wdata(dq_wdata), .dq_push(dq_push), .dq_pop(dq_pop),
    .dq_rdata(dq_rdata), .dq_full(dq_full), .dq_empty(dq_empty),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  int nchk = 0, nerr = 0;
  logic [7:0] exp_s [0:4095];
  logic [7:0] mon_s [0:4095];
  int exp_n = 0, mon_n = 0, chk_i = 0;
  int rise_cnt = 0;
  longint last_rise = -1, min_per = 1000000;

  function automatic logic [7:0] sl_val(int i);
    return 8'(i * 29 + 90) ^ 8'(i >> 3);
  endfunction

  // serial slave model
  int sl_byte = 0;
  logic [2:0] sl_bit = 3'd0;
  logic [7:0] sl_cur, mon_sh = 8'h00;
  int mon_bits = 0;
  assign sl_cur = sl_val(sl_byte);
  assign miso = sl_cur[3'd7 - sl_bit];

  always @(posedge sclk) begin
    rise_cnt++;
    if (last_rise >= 0 && ($time - last_rise) < min_per) min_per = $time - last_rise;
    last_rise = $time;
    if (!cs_n) begin
      mon_sh = {mon_sh[6:0], mosi};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_s[mon_n] = mon_sh; mon_n++; mon_bits = 0;
      end
    end
  end
  always @(negedge sclk) if (!cs_n) begin
    if (sl_bit == 3'd7) begin sl_bit = 3'd0; sl_byte++; end
    else sl_bit = sl_bit + 3'd1;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic commit(input logic [4:0] opc, input logic [8:0] len);
    while (op_full) tick();
    op_wdata = {opc, len}; op_ld = 1'b1; tick(); op_ld = 1'b0;
    op_commit = 1'b1; tick(); op_commit = 1'b0;
  endtask

  task automatic dpush(input logic [7:0] b);
    while (dq_full) tick();
    dq_wdata = b; dq_push = 1'b1; tick(); dq_push = 1'b0;
  endtask

  task automatic dpop(output logic [7:0] b);
    while (dq_empty) tick();
    b = dq_rdata; dq_pop = 1'b1; tick(); dq_pop = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!op_empty && n < 50000) begin tick(); n++; end
    tick();
  endtask

  task automatic check_stream(input string req);
    int bad = 0, first_a = 0, first_e = 0;
    wait_idle();
    for (int i = chk_i; i < exp_n; i++)
      if (mon_s[i] !== exp_s[i]) begin
        if (bad == 0) begin first_a = int'(mon_s[i]); first_e = int'(exp_s[i]); end
        bad++;
      end
    check(bad == 0 && mon_n == exp_n, req, (bad != 0) ? first_a : mon_n,
          (bad != 0) ? first_e : exp_n);
    chk_i = exp_n;
  endtask

  task automatic do_write(input int len, input bit gaps);
    commit(5'h08, 9'(len));
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      exp_s[exp_n] = b; exp_n++;
      dpush(b);
      if (gaps) repeat ($urandom % 3) tick();
    end
  endtask

  task automatic do_read(input int len, input string req);
    int bad = 0, base;
    logic [7:0] b, fa, fe;
    fa = 0; fe = 0;
    base = exp_n;
    commit(5'h0C, 9'(len));
    for (int i = 0; i < len; i++) begin
      dpop(b);
      if (b !== sl_val(base + i)) begin
        if (bad == 0) begin fa = b; fe = sl_val(base + i); end
        bad++;
      end
      repeat ($urandom % 4) tick();
    end
    check(bad == 0, req, fa, fe);
    for (int i = 0; i < len; i++) begin exp_s[exp_n] = 8'hFF; exp_n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int r0;
    void'($urandom(32'd1234));
    repeat (3) tick();
    // R1 reset state
    check(cs_n && !sclk && op_empty && dq_empty && !op_full && !dq_full, "R1",
          {cs_n, sclk, op_empty, dq_empty, op_full, dq_full}, 6'b101100);
    rst_n = 1'b1; tick();

    // R2 load without commit does nothing
    op_wdata = {5'h01, 9'd1}; op_ld = 1'b1; tick(); op_ld = 1'b0;
    repeat (10) tick();
    check(cs_n && op_empty, "R2", cs_n, 1);
    op_commit = 1'b1; tick(); op_commit = 1'b0;
    repeat (3) tick();
    // R3 select low
    check(!cs_n, "R3", cs_n, 0);

    // R11 unknown opcode and zero counts
    r0 = rise_cnt;
    commit(5'h05, 9'd3); commit(5'h08, 9'd0); commit(5'h0C, 9'd0);
    wait_idle();
    check(rise_cnt == r0 && !cs_n, "R11", rise_cnt - r0, 0);

    // R4 directed send
    commit(5'h08, 9'd3);
    foreach (exp_s[k]) if (k < 3) begin end
    exp_s[exp_n] = 8'hA5; exp_s[exp_n+1] = 8'h3C; exp_s[exp_n+2] = 8'h81; exp_n += 3;
    dpush(8'hA5); dpush(8'h3C); dpush(8'h81);
    check_stream("R4");
    // R10 bit spacing
    check(min_per == 2 * HDIV * CLK_P, "R10", min_per, 2 * HDIV * CLK_P);

    // R5 directed receive
    do_read(5, "R5");
    check_stream("R5");

    // R6 send stall
    r0 = rise_cnt;
    commit(5'h08, 9'd2);
    repeat (40) tick();
    check(rise_cnt == r0 && !sclk, "R6", rise_cnt - r0, 0);
    exp_s[exp_n] = 8'h6D; exp_s[exp_n+1] = 8'hF0; exp_n += 2;
    dpush(8'h6D); dpush(8'hF0);
    check_stream("R6");

    // R8 ordering and full flag
    commit(5'h08, 9'd1);
    commit(5'h00, 9'd1);
    for (int i = 0; i < 7; i++) commit(5'h05, 9'd1);
    check(op_full && !op_empty, "R8", {op_full, op_empty}, 2'b10);
    repeat (20) tick();
    check(!cs_n, "R8", cs_n, 0);
    exp_s[exp_n] = 8'h5E; exp_n++;
    dpush(8'h5E);
    check_stream("R8");
    check(cs_n && op_empty && !op_full, "R8", {cs_n, op_empty, op_full}, 3'b110);
    commit(5'h01, 9'd1);
    wait_idle();

    // R7 receive stall on full queue
    r0 = rise_cnt;
    commit(5'h0C, 9'd20);
    for (int n = 0; n < 2000 && !dq_full; n++) tick();
    repeat (100) tick();
    check(dq_full && !sclk && (rise_cnt - r0) == 17 * 8, "R7", rise_cnt - r0, 17 * 8);
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
        dpop(b);
        if (b !== sl_val(exp_n + i)) bad++;
      end
      check(bad == 0, "R7", bad, 0);
      for (int i = 0; i < 20; i++) begin exp_s[exp_n] = 8'hFF; exp_n++; end
    end
    check_stream("R7");

    // R9 flags, push on full, pop on empty
    for (int i = 0; i < 16; i++) dpush(8'(8'h10 + i));
    check(dq_full && !dq_empty, "R9", dq_full, 1);
    dq_wdata = 8'hEE; dq_push = 1'b1; tick(); dq_push = 1'b0;
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++) begin
        dpop(b);
        if (b !== 8'(8'h10 + i)) bad++;
      end
      check(bad == 0 && dq_empty, "R9", bad, 0);
    end
    dq_pop = 1'b1; tick(); dq_pop = 1'b0;
    dpush(8'h42);
    check(dq_rdata == 8'h42 && !dq_empty, "R9", dq_rdata, 8'h42);
    dpop(b);

    // R12 same-cycle push and pop
    dpush(8'h11); dpush(8'h22); dpush(8'h33);
    dq_wdata = 8'h44; dq_push = 1'b1; dq_pop = 1'b1; tick();
    dq_push = 1'b0; dq_pop = 1'b0;
    check(dq_rdata == 8'h22, "R12", dq_rdata, 8'h22);
    begin
      logic [7:0] x, y, z;
      dpop(x); dpop(y); dpop(z);
      check(x == 8'h22 && y == 8'h33 && z == 8'h44 && dq_empty, "R12", {x, y, z}, 24'h223344);
    end

    // R2 long counts
    do_write(300, 1'b0);
    check_stream("R2");
    do_read(511, "R2");
    check_stream("R2");

    // R4 / R5 random mix
    for (int it = 0; it < 12; it++) begin
      if ($urandom % 2) begin
        do_write(1 + int'($urandom % 40), 1'b1);
        check_stream("R4");
      end else begin
        do_read(1 + int'($urandom % 40), "R5");
        check_stream("R5");
      end
    end

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule